// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a synchronous host reach an external asynchronous static RAM of 512K words by 16 bits. The host offers one request at a time on a ready/valid port: a read or a write, an address, write data and a two-bit lane enable. The controller turns each request into a timed sequence on the memory pins. It drives the active-low and active-high chip selects, the write strobe, the output enable, the two active-low byte-lane strobes and the mode pin. It also drives the split data bus: data out, a drive enable for the pad tristate, and data in.

Every pulse width is a whole number of clock cycles. Each one is the ceiling of a nanosecond figure divided by the clock period, and the nanosecond figure comes from the chosen speed grade (40 or 55). With the defaults (5 ns clock, grade 40), a read takes 8 cycles from acceptance to data, and a write holds the strobe low for 8 cycles. The drivers turn on 4 cycles after the strobe falls. A parameter selects a by-8 mode, in which the host gives a byte address and only data lines 7:0 carry data. A second parameter deselects the memory whenever the controller is idle, so that the memory stays in standby between requests.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, every memory control is inactive: `sram_ce_n`=1, `sram_ce`=0, `sram_we_n`=1, `sram_oe_n`=1, both lane strobes 1 and `sram_dq_oe`=0, with `req_ready`=1 and `rsp_valid`=0. During every access the memory is selected with `sram_ce_n`=0 and `sram_ce`=1.
- R2: A write drives `sram_we_n` low from the edge that accepts it for WL cycles, then returns it high. WL is the largest of ceil(write pulse), ceil(select-to-end), ceil(write cycle) and ODW+DS. With the defaults WL is 8.
- R3: In a write, `sram_dq_oe` rises only once `sram_we_n` has been low for ODW = ceil(20 ns/clock) cycles (4). It stays high until the strobe rises, which gives at least DS = ceil(20 ns/clock) = 4 cycles of data before the end of the write. It falls on the same edge as the strobe rises, and it is never high while `sram_we_n` is high.
- R4: `sram_oe_n` stays high for every cycle in which `sram_we_n` is low.
- R5: A read drives `sram_oe_n` low from the accepting edge. It samples `sram_dq_i` RD = max(ceil(tRC), ceil(tOE)) cycles later (8 at the defaults) and shows it on `rsp_rdata` with a one-cycle `rsp_valid` pulse on that same edge.
- R6: In word mode, `req_be[0]` drives `sram_lb_n` low (data bits 7:0) and `req_be[1]` drives `sram_ub_n` low (bits 15:8). A write changes only the enabled lanes. A read returns the disabled lanes as zero.
- R7: `req_ready` is high only while the controller is idle, so a second request is not accepted until the current access has ended.
- R8: With IDLE_STANDBY=1, the memory is deselected (`sram_ce_n`=1, `sram_ce`=0) in every idle cycle.
- R9: With BYTE_MODE=1, host address bit 0 drives `sram_a_lsb` and the upper bits form `sram_addr`. In this mode `sram_byte_n`=0, `sram_lb_n`=0 and `sram_ub_n`=1, write data is {8'h00, wdata[7:0]}, and reads return {8'h00, dq[7:0]}. In word mode `sram_byte_n`=1 and `sram_a_lsb`=0.
- R10: `sram_addr` carries the host word address unchanged for the whole access, up to and including 19'h7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+BYTE_MODE | Word address, or byte address in by-8 mode |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Lane enables, bit 0 low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| sram_addr | output | ADDR_W | Memory word address |
| sram_a_lsb | output | 1 | Lowest byte-address pin for by-8 mode |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lb_n | output | 1 | Active-low lower-lane strobe |
| sram_ub_n | output | 1 | Active-low upper-lane strobe |
| sram_byte_n | output | 1 | Mode pin, low selects by-8 organisation |
| sram_dq_o | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Pad driver enable for sram_dq_o |
| sram_dq_i | input | DATA_W | Data from the memory |

## Verification
The assertions assume the host changes its request fields only while it holds `req_valid`. They also assume that reset is held low from time zero until the clock runs. The bench meets both: it drives inputs just after falling edges, holds each request until the accepting edge has passed, and releases reset only after several cycles. The bench's memory model and its latency checks assume the 5 ns clock and grade 40. The checker takes its own cycle counts from the controller's parameters, so it follows whatever grade and period are configured.

// File: rtl/sram_async_pkg.sv
`timescale 1ns/1ps
package sram_async_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2
   } ctrl_state_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // nanosecond minimums per speed grade (grade value equals cycle time)
   function automatic int t_oe_ns(input int grade);
      return (grade == 40) ? 25 : 30;
   endfunction

   function automatic int t_wp_ns(input int grade);
      return (grade == 40) ? 30 : 40;
   endfunction

   function automatic int t_cw_ns(input int grade);
      return (grade == 40) ? 35 : 45;
   endfunction

   function automatic int t_ds_ns(input int grade);
      return (grade == 40) ? 20 : 25;
   endfunction

   function automatic int t_hiz_ns(input int grade);
      return (grade == 40) ? 20 : 25;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (count != {CNT_W{1'b1}}) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/sram_addr_map.sv
`timescale 1ns/1ps
module sram_addr_map #(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 16,
   parameter int BYTE_MODE = 0,
   parameter int HOST_AW   = ADDR_W + BYTE_MODE
) (
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [1:0]         host_be,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [ADDR_W-1:0]  word_addr,
   output logic               addr_lsb,
   output logic               lb_n,
   output logic               ub_n,
   output logic [DATA_W-1:0]  dq_word,
   output logic               byte_n
);
   localparam int LANE_W = DATA_W / 2;

   generate
      if (BYTE_MODE != 0) begin : g_byte
         assign word_addr = host_addr[HOST_AW-1:1];
         assign addr_lsb  = host_addr[0];
         assign lb_n      = 1'b0;
         assign ub_n      = 1'b1;
         assign dq_word   = {{(DATA_W-LANE_W){1'b0}}, host_wdata[LANE_W-1:0]};
         assign byte_n    = 1'b0;
      end else begin : g_word
         assign word_addr = host_addr;
         assign addr_lsb  = 1'b0;
         assign lb_n      = ~host_be[0];
         assign ub_n      = ~host_be[1];
         assign dq_word   = host_wdata;
         assign byte_n    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
   parameter int DATA_W    = 16,
   parameter int BYTE_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              lb_n,
   input  logic              ub_n,
   input  logic [DATA_W-1:0] dq_in,
   output logic              valid,
   output logic [DATA_W-1:0] rdata
);
   localparam int LANE_W = DATA_W / 2;

   logic [DATA_W-1:0] masked;

   generate
      if (BYTE_MODE != 0) begin : g_byte
         assign masked = {{(DATA_W-LANE_W){1'b0}}, dq_in[LANE_W-1:0]};
      end else begin : g_word
         assign masked = {dq_in[DATA_W-1:LANE_W] & {(DATA_W-LANE_W){~ub_n}},
                          dq_in[LANE_W-1:0]      & {LANE_W{~lb_n}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         rdata <= '0;
      end else begin
         valid <= capture;
         if (capture) begin
            rdata <= masked;
         end
      end
   end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_async_pkg::*;
#(
   parameter int ADDR_W       = 19,
   parameter int DATA_W       = 16,
   parameter int CLK_NS       = 5,
   parameter int GRADE_NS     = 40,
   parameter int BYTE_MODE    = 0,
   parameter int IDLE_STANDBY = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_write,
   input  logic [ADDR_W+BYTE_MODE-1:0] req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic [1:0]                  req_be,
   output logic                        rsp_valid,
   output logic [DATA_W-1:0]           rsp_rdata,
   output logic [ADDR_W-1:0]           sram_addr,
   output logic                        sram_a_lsb,
   output logic                        sram_ce_n,
   output logic                        sram_ce,
   output logic                        sram_we_n,
   output logic                        sram_oe_n,
   output logic                        sram_lb_n,
   output logic                        sram_ub_n,
   output logic                        sram_byte_n,
   output logic [DATA_W-1:0]           sram_dq_o,
   output logic                        sram_dq_oe,
   input  logic [DATA_W-1:0]           sram_dq_i
);
   localparam int HOST_AW = ADDR_W + BYTE_MODE;
   localparam int RD_CYC  = imax(ns_to_cyc(GRADE_NS, CLK_NS),
                                 ns_to_cyc(t_oe_ns(GRADE_NS), CLK_NS));
   localparam int ODW_CYC = ns_to_cyc(t_hiz_ns(GRADE_NS), CLK_NS);
   localparam int DS_CYC  = ns_to_cyc(t_ds_ns(GRADE_NS), CLK_NS);
   localparam int WL_CYC  = imax(imax(ns_to_cyc(t_wp_ns(GRADE_NS), CLK_NS),
                                      ns_to_cyc(t_cw_ns(GRADE_NS), CLK_NS)),
                                 imax(ns_to_cyc(GRADE_NS, CLK_NS), ODW_CYC + DS_CYC));
   localparam int CNT_W   = $clog2(imax(RD_CYC, WL_CYC) + 1);
   localparam logic [CNT_W-1:0] ODW_LAST = CNT_W'(ODW_CYC - 1);
   localparam logic [CNT_W-1:0] WL_LAST  = CNT_W'(WL_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);

   // elaboration-time parameter checks
   generate
      if (GRADE_NS != 40 && GRADE_NS != 55) begin : g_bad_grade
         $error("speed grade must be 40 or 55");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("clock period must be positive");
      end
      if (DATA_W != 16) begin : g_bad_width
         $error("data bus must be 16 bits");
      end
      if (BYTE_MODE != 0 && BYTE_MODE != 1) begin : g_bad_mode
         $error("byte mode is 0 or 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("address width too small");
      end
   endgenerate

   ctrl_state_e        state;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  m_addr;
   logic               m_lsb;
   logic               m_lb_n;
   logic               m_ub_n;
   logic [DATA_W-1:0]  m_dq;
   logic               capture;

   sram_addr_map #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_MODE(BYTE_MODE), .HOST_AW(HOST_AW)
   ) u_map (
      .host_addr (req_addr),
      .host_be   (req_be),
      .host_wdata(req_wdata),
      .word_addr (m_addr),
      .addr_lsb  (m_lsb),
      .lb_n      (m_lb_n),
      .ub_n      (m_ub_n),
      .dq_word   (m_dq),
      .byte_n    (sram_byte_n)
   );

   sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(state == ST_IDLE),
      .count(cnt)
   );

   assign capture   = (state == ST_READ) && (cnt == RD_LAST);
   assign req_ready = (state == ST_IDLE);

   sram_read_capture #(.DATA_W(DATA_W), .BYTE_MODE(BYTE_MODE)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(capture),
      .lb_n   (sram_lb_n),
      .ub_n   (sram_ub_n),
      .dq_in  (sram_dq_i),
      .valid  (rsp_valid),
      .rdata  (rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sram_addr  <= '0;
         sram_a_lsb <= 1'b0;
         sram_ce_n  <= 1'b1;
         sram_ce    <= 1'b0;
         sram_we_n  <= 1'b1;
         sram_oe_n  <= 1'b1;
         sram_lb_n  <= 1'b1;
         sram_ub_n  <= 1'b1;
         sram_dq_o  <= '0;
         sram_dq_oe <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  sram_addr  <= m_addr;
                  sram_a_lsb <= m_lsb;
                  sram_lb_n  <= m_lb_n;
                  sram_ub_n  <= m_ub_n;
                  sram_ce_n  <= 1'b0;
                  sram_ce    <= 1'b1;
                  if (req_write) begin
                     sram_we_n <= 1'b0;
                     sram_dq_o <= m_dq;
                     state     <= ST_WRITE;
                  end else begin
                     sram_oe_n <= 1'b0;
                     state     <= ST_READ;
                  end
               end else if (IDLE_STANDBY != 0) begin
                  sram_ce_n <= 1'b1;
                  sram_ce   <= 1'b0;
               end
            end
            ST_WRITE: begin
               if (cnt == ODW_LAST) begin
                  sram_dq_oe <= 1'b1;
               end
               if (cnt == WL_LAST) begin
                  sram_we_n  <= 1'b1;
                  sram_dq_oe <= 1'b0;
                  sram_lb_n  <= 1'b1;
                  sram_ub_n  <= 1'b1;
                  if (IDLE_STANDBY != 0) begin
                     sram_ce_n <= 1'b1;
                     sram_ce   <= 1'b0;
                  end
                  state <= ST_IDLE;
               end
            end
            ST_READ: begin
               if (cnt == RD_LAST) begin
                  sram_oe_n <= 1'b1;
                  sram_lb_n <= 1'b1;
                  sram_ub_n <= 1'b1;
                  if (IDLE_STANDBY != 0) begin
                     sram_ce_n <= 1'b1;
                     sram_ce   <= 1'b0;
                  end
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
   parameter int ODW_CYC = 4,
   parameter int WL_CYC  = 8,
   parameter int STANDBY = 1
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rsp_valid,
   input logic sram_ce_n,
   input logic sram_ce,
   input logic sram_we_n,
   input logic sram_oe_n,
   input logic sram_dq_oe
);
   logic [15:0] we_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low <= '0;
      end else if (sram_we_n) begin
         we_low <= '0;
      end else if (we_low != 16'hFFFF) begin
         we_low <= we_low + 16'd1;
      end
   end

   AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_ce_n && sram_ce));                           // R1
   AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (int'(we_low) >= WL_CYC));                    // R2
   AST_DRIVE_AFTER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> (int'(we_low) >= ODW_CYC));                  // R3
   AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> !sram_we_n);                                        // R3
   AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);                                         // R4
   AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!sram_oe_n));                                  // R5
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);                                         // R5
   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_we_n && sram_oe_n));                           // R7
   AST_STANDBY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (STANDBY != 0 && req_ready) |-> (sram_ce_n && !sram_ce));          // R8
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ODW_CYC(ODW_CYC), .WL_CYC(WL_CYC), .STANDBY(IDLE_STANDBY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .sram_ce_n (sram_ce_n),
   .sram_ce   (sram_ce),
   .sram_we_n (sram_we_n),
   .sram_oe_n (sram_oe_n),
   .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
   localparam int CLK_NS = 5;

   function automatic int cdiv(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int RD_EXP  = mx(cdiv(40), cdiv(25));
   localparam int ODW_EXP = cdiv(20);
   localparam int DS_EXP  = cdiv(20);
   localparam int WL_EXP  = mx(mx(cdiv(30), cdiv(35)), mx(cdiv(40), ODW_EXP + DS_EXP));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;
   int cyc = 0;
   always @(posedge clk) cyc = cyc + 1;

   int n_chk = 0;
   int n_err = 0;

   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [19:0] b8_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [18:0] sram_addr;
   logic        sram_a_lsb, sram_ce_n, sram_ce, sram_we_n, sram_oe_n;
   logic        sram_lb_n, sram_ub_n, sram_byte_n, sram_dq_oe;
   logic [15:0] sram_dq_o, sram_dq_i;

   logic        b8_ready, b8_rsp_valid;
   logic [15:0] b8_rsp_rdata;
   logic [18:0] b8_sram_addr;
   logic        b8_a_lsb, b8_ce_n, b8_ce, b8_we_n, b8_oe_n, b8_lb_n, b8_ub_n, b8_byte_n, b8_dq_oe;
   logic [15:0] b8_dq_o;

   sram_async_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
      .sram_a_lsb(sram_a_lsb), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n),
      .sram_ub_n(sram_ub_n), .sram_byte_n(sram_byte_n), .sram_dq_o(sram_dq_o),
      .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
   );

   sram_async_ctrl #(.BYTE_MODE(1)) dut_b8 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b8_ready),
      .req_write(req_write), .req_addr(b8_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(b8_rsp_valid), .rsp_rdata(b8_rsp_rdata), .sram_addr(b8_sram_addr),
      .sram_a_lsb(b8_a_lsb), .sram_ce_n(b8_ce_n), .sram_ce(b8_ce),
      .sram_we_n(b8_we_n), .sram_oe_n(b8_oe_n), .sram_lb_n(b8_lb_n),
      .sram_ub_n(b8_ub_n), .sram_byte_n(b8_byte_n), .sram_dq_o(b8_dq_o),
      .sram_dq_oe(b8_dq_oe), .sram_dq_i(16'h5AA5)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // behavioural memory: lanes that are not driven read as EE
   logic        sel;
   logic [15:0] mem [256];
   assign sel = !sram_ce_n && sram_ce;
   assign sram_dq_i = (sel && !sram_oe_n && sram_we_n) ?
                      {sram_ub_n ? 8'hEE : mem[sram_addr[7:0]][15:8],
                       sram_lb_n ? 8'hEE : mem[sram_addr[7:0]][7:0]} : 16'hEEEE;

   int          wlow = 0, drv = 0;
   logic [15:0] wdat;
   logic        lbs, ubs;
   logic [7:0]  wa;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sram_we_n) begin
            wlow++;
            lbs = sram_lb_n; ubs = sram_ub_n; wa = sram_addr[7:0];
            chk(sel, "R1", "selected while strobe low", {31'd0, sel}, 1);
            chk(sram_oe_n, "R4", "output enable high during write", {31'd0, sram_oe_n}, 1);
            if (sram_dq_oe) begin
               if (drv == 0)
                  chk(wlow - 1 >= ODW_EXP, "R3", "cycles of strobe low before drive", wlow - 1, ODW_EXP);
               drv++;
               wdat = sram_dq_o;
            end
         end else begin
            if (sram_dq_oe) chk(1'b0, "R3", "drive outside write", 1, 0);
            if (wlow > 0) begin
               chk(wlow == WL_EXP, "R2", "strobe low cycles", wlow, WL_EXP);
               chk(drv >= DS_EXP, "R3", "data setup cycles", drv, DS_EXP);
               if (!lbs) mem[wa][7:0]  = wdat[7:0];
               if (!ubs) mem[wa][15:8] = wdat[15:8];
               wlow = 0;
               drv  = 0;
            end
         end
      end
   end

   // scoreboard
   logic [15:0] exp_q [$];
   int          due_q [$];
   logic [15:0] ref_mem [256];
   logic [15:0] pe;
   int          pd;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected response", 1, 0);
            end else begin
               pe = exp_q.pop_front();
               pd = due_q.pop_front();
               chk(rsp_rdata === pe, "R6", "read data", {16'd0, rsp_rdata}, {16'd0, pe});
               chk(cyc == pd, "R5", "read latency", cyc, pd);
            end
         end
         if (b8_rsp_valid)
            chk(b8_rsp_rdata === 16'h00A5, "R9", "by-8 read data", {16'd0, b8_rsp_rdata}, 32'h00A5);
      end
   end

   task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be);
      int acc;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; b8_addr = {a, 1'b1};
      req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      if (!wr) begin
         exp_q.push_back(ref_mem[a[7:0]] & {{8{be[1]}}, {8{be[0]}}});
         due_q.push_back(acc + RD_EXP);
      end else begin
         if (be[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
         if (be[1]) ref_mem[a[7:0]][15:8] = d[15:8];
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk(!req_ready, "R7", "ready low while busy", {31'd0, req_ready}, 0);
      chk(!sram_ce_n && sram_ce, "R1", "chip selected", {30'd0, sram_ce_n, sram_ce}, 1);
      chk(sram_addr == a, "R10", "word address", {13'd0, sram_addr}, {13'd0, a});
      chk({sram_ub_n, sram_lb_n} == ~be, "R6", "lane strobes", {30'd0, sram_ub_n, sram_lb_n}, {30'd0, ~be});
      chk(sram_we_n == !wr, "R2", "strobe level", {31'd0, sram_we_n}, {31'd0, !wr});
      chk(sram_oe_n == wr, "R5", "output enable level", {31'd0, sram_oe_n}, {31'd0, wr});
      chk(b8_sram_addr == a && b8_a_lsb && !b8_byte_n && !b8_lb_n && b8_ub_n, "R9",
          "by-8 address split and pins", {13'd0, b8_sram_addr}, {13'd0, a});
      if (wr) chk(b8_dq_o == {8'h00, d[7:0]}, "R9", "by-8 write data", {16'd0, b8_dq_o}, {24'd0, d[7:0]});
      while (!req_ready) @(negedge clk);
      chk(sram_ce_n && !sram_ce, "R8", "deselected when idle", {30'd0, sram_ce_n, sram_ce}, 2);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R7", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = 16'h0000;
         ref_mem[i] = 16'h0000;
      end
      repeat (3) @(negedge clk);
      // R1 reset state, R9 word-mode pins
      chk(req_ready && !rsp_valid, "R1", "reset ready/valid", {30'd0, req_ready, rsp_valid}, 2);
      chk(sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
          "R1", "reset controls inactive", {25'd0, sram_ce_n, sram_ce, sram_we_n, sram_oe_n,
          sram_lb_n, sram_ub_n, sram_dq_oe}, 32'h5E);
      chk(sram_byte_n && !sram_a_lsb, "R9", "word mode pins", {30'd0, sram_byte_n, sram_a_lsb}, 2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sram_ce_n && !sram_ce, "R8", "standby after reset", {30'd0, sram_ce_n, sram_ce}, 2);

      issue(1'b1, 19'h00010, 16'h1234, 2'b11);
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);   // R5 full word 1234
      issue(1'b1, 19'h00010, 16'hABCD, 2'b01);   // R6 lower lane only
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);   // expect 12CD
      issue(1'b1, 19'h00010, 16'hEF99, 2'b10);   // R6 upper lane only
      issue(1'b0, 19'h00010, 16'h0000, 2'b11);   // expect EFCD
      issue(1'b0, 19'h00010, 16'h0000, 2'b01);   // expect 00CD
      issue(1'b0, 19'h00010, 16'h0000, 2'b10);   // expect EF00
      issue(1'b1, 19'h7FFFF, 16'hA5C3, 2'b11);   // R10 top address
      issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
      issue(1'b1, 19'h00000, 16'h0F0F, 2'b11);
      issue(1'b1, 19'h00020, 16'h7777, 2'b00);   // no lane enabled, nothing written
      issue(1'b0, 19'h00000, 16'h0000, 2'b11);
      issue(1'b0, 19'h00020, 16'h0000, 2'b11);   // still zero
      issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5", "all reads answered", exp_q.size(), 0);
      finish_run();
   end
endmodule